// File: doc/BRIEF.md
# Floating-point condition code and flag generator

This block produces the condition-code bits of a floating-point status word and the carry, zero and parity integer flags. It serves three kinds of operation. A compare folds a relation code (less, equal, greater, unordered), computed elsewhere, into either the status condition bits or the integer flags. A classify inspects an 80-bit extended operand (sign, 15-bit biased exponent, 64-bit significand with an explicit integer bit) and encodes its kind. A remainder step writes either the low three quotient bits, spread over non-adjacent condition positions, or an "incomplete" marker.

Each cycle with the valid strobe high, the block takes the current status word, rewrites only the condition bits the selected operation owns, and registers the result. The integer flags are held in registers and change only on a compare to integer flags. With the strobe low, every output holds.

Condition-bit positions in the 16-bit status word: C0 is bit 8, C1 is bit 9, C2 is bit 10, C3 is bit 14. Operation select `op_i`: 0 compare to status, 1 compare to integer flags, 2 classify, 3 remainder complete, 4 remainder incomplete, 5 to 7 reserved. Relation code `cmp_i`: 0 less, 1 equal, 2 greater, 3 unordered.

Top module: `fcc_unit`

## Requirements
- R1: With op 0, C3, C2 and C0 are first cleared; less then sets C0, equal sets C3, greater sets nothing, unordered sets C3, C2 and C0 together.
- R2: With op 0, C1 and every bit outside C3/C2/C0 keep the value of `stat_i`.
- R3: With op 1, less sets CF only, equal sets ZF only, greater clears all three, unordered sets CF, ZF and PF.
- R4: With op 1, `stat_o` becomes `stat_i` unchanged; with any other op the three integer flags keep their previous values.
- R5: With op 2, C3 to C0 are cleared and C1 takes the sign bit.
- R6: With op 2 and an all-ones exponent (0x7FFF), a significand of exactly 0x8000000000000000 gives infinity (C2 and C0); any other significand gives NaN (C0 only). This test is made before any other.
- R7: With op 2 and a zero exponent, a zero significand gives zero (C3); a nonzero significand gives denormal (C3 and C2).
- R8: With op 2 and any other exponent, the result is normal (C2 only), whatever the significand.
- R9: With op 3, C3 to C0 are cleared, then quotient bit 2 goes to C0, bit 1 to C3 and bit 0 to C1; C2 stays clear.
- R10: With op 4, C3 to C0 are cleared and C2 alone is set.
- R11: For every op, bits outside mask 0x4700 of `stat_o` equal those of `stat_i`; reserved ops 5 to 7 pass `stat_i` through whole.
- R12: Outputs update one clock after a cycle with `valid_i` high and hold while `valid_i` is low; reset clears `stat_o` and all three flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation select |
| sign_i | input | 1 | Operand sign |
| exp_i | input | 15 | Operand biased exponent |
| sig_i | input | 64 | Operand significand with integer bit |
| cmp_i | input | 2 | Relation code from the comparator |
| quo_i | input | 3 | Low three quotient bits |
| stat_i | input | 16 | Current status word |
| stat_o | output | 16 | Updated status word, registered |
| cf_o | output | 1 | Carry flag, registered |
| zf_o | output | 1 | Zero flag, registered |
| pf_o | output | 1 | Parity flag, registered |

## Verification
Classify is driven with exponents biased toward all-ones, zero and mid values and significands biased toward zero, the lone integer bit and random words, which separates infinity from NaN, zero from denormal, and shows that a normal exponent ignores the significand. Compares run all four relation codes against random status words, so that the preserved C1 and the triple flag set for unordered stand apart from the single-bit cases. Quotient patterns 1, 2 and 4 each light one distinct condition bit, exposing any swap of the scattered positions, and idle cycles with changing inputs show that outputs hold.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [2:0] {
    OP_FCMP     = 3'd0,
    OP_ICMP     = 3'd1,
    OP_CLASS    = 3'd2,
    OP_REM_DONE = 3'd3,
    OP_REM_PART = 3'd4
  } fcc_op_e;

  typedef enum logic [1:0] {
    CMP_LT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GT = 2'd2,
    CMP_UN = 2'd3
  } fcc_cmp_e;

  localparam int C0_POS = 8;
  localparam int C1_POS = 9;
  localparam int C2_POS = 10;
  localparam int C3_POS = 14;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
    logic c0;
  } cc_t;

  typedef struct packed {
    logic cf;
    logic zf;
    logic pf;
  } iflag_t;
endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
  import fcc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output cc_t              cc_o
);
  localparam logic [SIG_W-1:0] SIG_INT_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

  logic exp_max, exp_zero, sig_zero, sig_inf;

  assign exp_max  = &exp_i;
  assign exp_zero = ~|exp_i;
  assign sig_zero = ~|sig_i;
  assign sig_inf  = (sig_i == SIG_INT_ONLY);

  // priority: all-ones exponent, then zero exponent, then normal
  always_comb begin
    cc_o    = '0;
    cc_o.c1 = sign_i;
    if (exp_max) begin
      cc_o.c0 = 1'b1;
      cc_o.c2 = sig_inf;
    end else if (exp_zero) begin
      cc_o.c3 = 1'b1;
      cc_o.c2 = ~sig_zero;
    end else begin
      cc_o.c2 = 1'b1;
    end
  end
endmodule

// File: rtl/fcc_cmp_map.sv
module fcc_cmp_map
  import fcc_pkg::*;
(
  input  logic [1:0] cmp_i,
  output cc_t        cc_o,
  output iflag_t     fl_o
);
  always_comb begin
    cc_o = '0;
    fl_o = '0;
    unique case (fcc_cmp_e'(cmp_i))
      CMP_LT: begin
        cc_o.c0 = 1'b1;
        fl_o.cf = 1'b1;
      end
      CMP_EQ: begin
        cc_o.c3 = 1'b1;
        fl_o.zf = 1'b1;
      end
      CMP_GT: ;
      CMP_UN: begin
        cc_o.c3 = 1'b1;
        cc_o.c2 = 1'b1;
        cc_o.c0 = 1'b1;
        fl_o    = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fcc_rem_pack.sv
module fcc_rem_pack
  import fcc_pkg::*;
(
  input  logic       done_i,
  input  logic [2:0] quo_i,
  output cc_t        cc_o
);
  always_comb begin
    cc_o = '0;
    if (done_i) begin
      cc_o.c0 = quo_i[2];
      cc_o.c3 = quo_i[1];
      cc_o.c1 = quo_i[0];
    end else begin
      cc_o.c2 = 1'b1;
    end
  end
endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
  import fcc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  parameter int SW_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [1:0]       cmp_i,
  input  logic [2:0]       quo_i,
  input  logic [SW_W-1:0]  stat_i,
  output logic [SW_W-1:0]  stat_o,
  output logic             cf_o,
  output logic             zf_o,
  output logic             pf_o
);
  localparam int NCC = 4;
  localparam int CC_POS [NCC] = '{C3_POS, C2_POS, C1_POS, C0_POS};

  fcc_op_e op;
  cc_t     cls_cc, cmp_cc, rem_cc, new_cc, wr_mask;
  iflag_t  cmp_fl, fl_q;
  logic [SW_W-1:0] stat_d, stat_q;

  assign op = fcc_op_e'(op_i);

  fcc_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
    .sign_i (sign_i),
    .exp_i  (exp_i),
    .sig_i  (sig_i),
    .cc_o   (cls_cc)
  );

  fcc_cmp_map u_cmp (
    .cmp_i (cmp_i),
    .cc_o  (cmp_cc),
    .fl_o  (cmp_fl)
  );

  fcc_rem_pack u_rem (
    .done_i (op == OP_REM_DONE),
    .quo_i  (quo_i),
    .cc_o   (rem_cc)
  );

  always_comb begin
    new_cc  = '0;
    wr_mask = '0;
    case (op)
      OP_FCMP: begin
        new_cc  = cmp_cc;
        wr_mask = '{c3: 1'b1, c2: 1'b1, c1: 1'b0, c0: 1'b1};
      end
      OP_CLASS: begin
        new_cc  = cls_cc;
        wr_mask = '1;
      end
      OP_REM_DONE, OP_REM_PART: begin
        new_cc  = rem_cc;
        wr_mask = '1;
      end
      default: ;
    endcase
  end

  // merge owned condition bits into the incoming word
  always_comb begin
    stat_d = stat_i;
    for (int k = 0; k < NCC; k++) begin
      if (wr_mask[NCC-1-k]) stat_d[CC_POS[k]] = new_cc[NCC-1-k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      fl_q   <= '0;
    end else if (valid_i) begin
      stat_q <= stat_d;
      if (op == OP_ICMP) fl_q <= cmp_fl;
    end
  end

  assign stat_o = stat_q;
  assign cf_o   = fl_q.cf;
  assign zf_o   = fl_q.zf;
  assign pf_o   = fl_q.pf;
endmodule

// File: rtl/fcc_unit_chk.sv
module fcc_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic        sign_i,
  input logic [1:0]  cmp_i,
  input logic [2:0]  quo_i,
  input logic [15:0] stat_i,
  input logic [15:0] stat_o,
  input logic        cf_o,
  input logic        zf_o,
  input logic        pf_o
);
  // R2
  fcmp_keep_c1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd0 |=> stat_o[9] == $past(stat_i[9]));

  // R1
  fcmp_unord_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd0 && cmp_i == 2'd3 |=> stat_o[14] && stat_o[10] && stat_o[8]);

  // R3
  icmp_unord_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 && cmp_i == 2'd3 |=> cf_o && zf_o && pf_o);

  // R3
  icmp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 && cmp_i != 2'd3 |=> $onehot0({cf_o, zf_o}) && !pf_o);

  // R4
  icmp_stat_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 |=> stat_o == $past(stat_i));

  // R4
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != 3'd1 |=> $stable({cf_o, zf_o, pf_o}));

  // R5
  class_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd2 |=> stat_o[9] == $past(sign_i));

  // R9
  rem_scatter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd3 |=> {stat_o[8], stat_o[14], stat_o[9], stat_o[10]} == {$past(quo_i), 1'b0});

  // R10
  rem_part_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd4 |=> {stat_o[14], stat_o[10], stat_o[9], stat_o[8]} == 4'b0100);

  // R11
  outside_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (stat_o & ~16'h4700) == ($past(stat_i) & ~16'h4700));

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(stat_o) && $stable({cf_o, zf_o, pf_o}));
endmodule

bind fcc_unit fcc_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .sign_i  (sign_i),
  .cmp_i   (cmp_i),
  .quo_i   (quo_i),
  .stat_i  (stat_i),
  .stat_o  (stat_o),
  .cf_o    (cf_o),
  .zf_o    (zf_o),
  .pf_o    (pf_o)
);

// File: tb/tb_fcc_unit.sv
module tb_fcc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic        sign = 1'b0;
  logic [14:0] expo = '0;
  logic [63:0] sig = '0;
  logic [1:0]  cmp = '0;
  logic [2:0]  quo = '0;
  logic [15:0] stat_in = '0;
  logic [15:0] stat_out;
  logic        cf, zf, pf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_stat = '0;
  logic [2:0]  m_fl = '0; // {cf,zf,pf}

  always #10 clk = ~clk;

  fcc_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .sign_i(sign),
    .exp_i(expo), .sig_i(sig), .cmp_i(cmp), .quo_i(quo), .stat_i(stat_in),
    .stat_o(stat_out), .cf_o(cf), .zf_o(zf), .pf_o(pf)
  );

  function automatic logic [15:0] ref_stat(logic [2:0] o, logic s, logic [14:0] e,
                                            logic [63:0] m, logic [1:0] c,
                                            logic [2:0] q, logic [15:0] st);
    logic [15:0] r = st;
    case (o)
      3'd0: begin
        r[14] = 0; r[10] = 0; r[8] = 0;
        if (c == 2'd0) r[8] = 1;
        if (c == 2'd1) r[14] = 1;
        if (c == 2'd3) begin r[14] = 1; r[10] = 1; r[8] = 1; end
      end
      3'd2: begin
        r[14] = 0; r[10] = 0; r[8] = 0; r[9] = s;
        if (e == 15'h7fff) begin
          r[8] = 1;
          if (m == 64'h8000_0000_0000_0000) r[10] = 1;
        end else if (e == 15'h0) begin
          r[14] = 1;
          if (m != 64'h0) r[10] = 1;
        end else r[10] = 1;
      end
      3'd3: begin
        r[10] = 0; r[8] = q[2]; r[14] = q[1]; r[9] = q[0];
      end
      3'd4: begin
        r[14] = 0; r[9] = 0; r[8] = 0; r[10] = 1;
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] ref_fl(logic [1:0] c);
    case (c)
      2'd0: return 3'b100;
      2'd1: return 3'b010;
      2'd2: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] o, logic [14:0] e);
    case (o)
      3'd0: return "R1/R2";
      3'd1: return "R3/R4";
      3'd2: return (e == 15'h7fff) ? "R5/R6" : (e == 0) ? "R5/R7" : "R5/R8";
      3'd3: return "R9";
      3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag);
    n_chk++;
    if ({stat_out, cf, zf, pf} !== {m_stat, m_fl}) begin
      n_bad++;
      $display("FAIL %s: got stat=%h fl=%b expected stat=%h fl=%b",
               tag, stat_out, {cf, zf, pf}, m_stat, m_fl);
    end
  endtask

  // drive on negedge, registered at next posedge, checked at following negedge
  task automatic run(logic v, logic [2:0] o, logic s, logic [14:0] e, logic [63:0] m,
                     logic [1:0] c, logic [2:0] q, logic [15:0] st, string tag);
    valid = v; op = o; sign = s; expo = e; sig = m; cmp = c; quo = q; stat_in = st;
    if (v) begin
      m_stat = ref_stat(o, s, e, m, c, q, st);
      if (o == 3'd1) m_fl = ref_fl(c);
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 each relation, R2 C1 preserved
    run(1, 0, 0, 0, 0, 2'd0, 0, 16'hffff, "R1 less");
    run(1, 0, 0, 0, 0, 2'd1, 0, 16'h0200, "R1 equal/R2 C1 kept");
    run(1, 0, 0, 0, 0, 2'd2, 0, 16'hbaff, "R1 greater");
    run(1, 0, 0, 0, 0, 2'd3, 0, 16'h0000, "R1 unordered");
    // R3 flags, R4 status unchanged
    run(1, 1, 0, 0, 0, 2'd3, 0, 16'h1234, "R3 unordered/R4");
    run(1, 1, 0, 0, 0, 2'd0, 0, 16'h5a5a, "R3 less");
    run(1, 1, 0, 0, 0, 2'd1, 0, 16'h0000, "R3 equal");
    run(1, 1, 0, 0, 0, 2'd2, 0, 16'hffff, "R3 greater");
    run(1, 1, 0, 0, 0, 2'd1, 0, 16'h0000, "R3 equal again");
    run(1, 0, 0, 0, 0, 2'd3, 0, 16'h0000, "R4 flags held on other op");
    // R5..R8 classify
    run(1, 2, 1, 15'h7fff, 64'h8000_0000_0000_0000, 0, 0, 16'hffff, "R6 infinity/R5 sign");
    run(1, 2, 0, 15'h7fff, 64'h8000_0000_0000_0001, 0, 0, 16'h0000, "R6 NaN");
    run(1, 2, 0, 15'h7fff, 64'h0, 0, 0, 16'h4700, "R6 NaN zero sig");
    run(1, 2, 1, 15'h0, 64'h0, 0, 0, 16'h0000, "R7 zero");
    run(1, 2, 0, 15'h0, 64'h1, 0, 0, 16'hffff, "R7 denormal");
    run(1, 2, 0, 15'h0001, 64'h0, 0, 0, 16'h0000, "R8 normal zero sig");
    run(1, 2, 1, 15'h7ffe, 64'h8000_0000_0000_0000, 0, 0, 16'h0000, "R8 normal max-1");
    // R9 quotient scatter
    run(1, 3, 0, 0, 0, 0, 3'b100, 16'h4700, "R9 q2->C0");
    run(1, 3, 0, 0, 0, 0, 3'b010, 16'h0000, "R9 q1->C3");
    run(1, 3, 0, 0, 0, 0, 3'b001, 16'h0400, "R9 q0->C1");
    run(1, 3, 0, 0, 0, 0, 3'b111, 16'h0000, "R9 all");
    // R10
    run(1, 4, 0, 0, 0, 0, 3'b111, 16'hffff, "R10 partial");
    // R11 reserved
    run(1, 5, 1, 0, 0, 2'd3, 3'b111, 16'h4321, "R11 reserved 5");
    run(1, 7, 1, 0, 0, 2'd3, 3'b111, 16'hbeef, "R11 reserved 7");
    // R12 hold while idle
    run(0, 1, 1, 15'h7fff, 64'h0, 2'd3, 3'b111, 16'h0f0f, "R12 idle hold");
    run(0, 2, 0, 15'h0, 64'h0, 2'd0, 3'b000, 16'hf0f0, "R12 idle hold 2");

    for (int i = 0; i < 600; i++) begin
      logic [2:0]  o;
      logic [14:0] e;
      logic [63:0] m;
      logic        v;
      o = 3'($urandom_range(0, 7));
      v = ($urandom_range(0, 5) != 0);
      case ($urandom_range(0, 2))
        0: e = 15'h7fff;
        1: e = 15'h0;
        default: e = 15'($urandom);
      endcase
      case ($urandom_range(0, 2))
        0: m = 64'h0;
        1: m = 64'h8000_0000_0000_0000;
        default: m = {$urandom, $urandom};
      endcase
      run(v, o, 1'($urandom), e, m, 2'($urandom), 3'($urandom), 16'($urandom),
          v ? tag_of(o, e) : "R12 random idle");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule